// File: doc/BRIEF.md
# Keyed Watchdog Timer with Prescaler

This block is a watchdog for an always-on power domain, clocked from a slow timebase of about 31.25 kHz, so one unscaled tick lasts 32 µs. A free-running counter advances when its run mode allows. The counter is shifted right by a programmable power-of-two exponent, and the result is compared with a 16-bit threshold. When the shifted value reaches the threshold, the block sets a pending flag. If reset generation is enabled, it also fires a one-cycle reset pulse. As a further option, the counter can clear itself on a match.

Software reaches the block through a simple 32-bit read/write port. Every write must come straight after a write of a magic key, and that unlock serves exactly one write. The watchdog is serviced by writing a second magic word to the feed register, which returns the counter to zero. Reads never need the key. The bus bridge, the clock source and the system reset network lie outside this block.

Top module: `kwdt_top`

## Requirements
- R1: A write is accepted only when the write just before it put 0x0051F15E into the key register (offset 0x1C). Without that unlock, a write to any register leaves every register unchanged.
- R2: An unlock is spent by the next write to any other register, even when that write changes nothing, such as a write to the read-only raw count (0x08).
- R3: An accepted write of 0x0D09F00D to the feed register (0x18) clears the counter to zero. Any other value written there leaves the counter unchanged.
- R4: Configuration (offset 0x00) bit 12 makes the counter advance every cycle. Bit 13 makes it advance only while `core_awake` is high. With both bits clear, the counter holds its value.
- R5: The scaled count register (0x10) reads the raw counter shifted right by configuration bits [3:0].
- R6: The pending flag (configuration bit 28) sets once the scaled count is at or above the compare register (0x20, bits [15:0]). An accepted configuration write with bit 28 at 0 clears it. `irq_pending` mirrors the flag.
- R7: When configuration bit 8 is set, `wdt_reset` is high for exactly one cycle, in the cycle the pending flag becomes set. When bit 8 is clear, `wdt_reset` never rises.
- R8: With configuration bit 9 set, a match clears the counter, so the raw count never exceeds the compare value while the scale is 0.
- R9: The counter saturates at its all-ones value instead of wrapping.
- R10: After reset, configuration reads 0, the raw count reads 0 and the compare register reads 0xFFFF. All registers can be read without the key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_awake | input | 1 | Core-awake status, gates counting in bit-13 mode |
| bus_addr | input | 6 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq_pending | output | 1 | Pending flag (configuration bit 28) |
| wdt_reset | output | 1 | One-cycle reset request |

## Verification
The assertions assume that `bus_wr` is a clean one-cycle strobe, that address and data are stable around the sampling edge, and that the reset is held for at least one edge. The bench drives all bus signals on the falling edge, raises the strobe for exactly one cycle per write, and drives `core_awake` in the same way. It uses a 10-bit counter so that saturation can be reached. Rate checks compare two count samples a fixed number of cycles apart rather than absolute values, so they do not depend on the latency of a write.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
   localparam int DATA_W       = 32;
   // register byte offsets
   localparam int OFF_CFG      = 'h00;
   localparam int OFF_RAW      = 'h08;
   localparam int OFF_SCALED   = 'h10;
   localparam int OFF_FEED     = 'h18;
   localparam int OFF_KEY      = 'h1C;
   localparam int OFF_CMP      = 'h20;
   // configuration bit positions
   localparam int B_RST_EN     = 8;
   localparam int B_AUTO_CLR   = 9;
   localparam int B_RUN_ALWAYS = 12;
   localparam int B_RUN_AWAKE  = 13;
   localparam int B_PEND       = 28;
   // magic words
   localparam logic [31:0] UNLOCK_WORD = 32'h0051_F15E;
   localparam logic [31:0] FEED_WORD   = 32'h0D09_F00D;

   typedef struct packed {
      logic run_awake;
      logic run_always;
      logic auto_clr;
      logic rst_en;
   } mode_t;
endpackage

// File: rtl/kwdt_regs.sv
module kwdt_regs
   import kwdt_pkg::*;
#(
   parameter int ADDR_W  = 6,
   parameter int CMP_W   = 16,
   parameter int SCALE_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_wr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output mode_t              mode,
   output logic [SCALE_W-1:0] scale,
   output logic [CMP_W-1:0]   cmp,
   output logic               pend_wr,
   output logic               pend_wval,
   output logic               feed_clr
);
   localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(OFF_CFG);
   localparam logic [ADDR_W-1:0] A_FEED = ADDR_W'(OFF_FEED);
   localparam logic [ADDR_W-1:0] A_KEY  = ADDR_W'(OFF_KEY);
   localparam logic [ADDR_W-1:0] A_CMP  = ADDR_W'(OFF_CMP);

   logic unlocked;
   logic key_hit;
   logic accept;

   assign key_hit = bus_wr && (bus_addr == A_KEY) && (bus_wdata == UNLOCK_WORD);
   assign accept  = bus_wr && unlocked && (bus_addr != A_KEY);

   // one-shot unlock: any write other than the key word spends it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      unlocked <= 1'b0;
      else if (bus_wr) unlocked <= key_hit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode  <= '0;
         scale <= '0;
         cmp   <= '1;
      end else if (accept) begin
         if (bus_addr == A_CFG) begin
            scale           <= bus_wdata[SCALE_W-1:0];
            mode.rst_en     <= bus_wdata[B_RST_EN];
            mode.auto_clr   <= bus_wdata[B_AUTO_CLR];
            mode.run_always <= bus_wdata[B_RUN_ALWAYS];
            mode.run_awake  <= bus_wdata[B_RUN_AWAKE];
         end
         if (bus_addr == A_CMP) cmp <= bus_wdata[CMP_W-1:0];
      end
   end

   assign pend_wr   = accept && (bus_addr == A_CFG);
   assign pend_wval = bus_wdata[B_PEND];
   assign feed_clr  = accept && (bus_addr == A_FEED) && (bus_wdata == FEED_WORD);

   AST_LOCKED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !unlocked) |=> ($stable(cmp) && $stable(mode) && $stable(scale))); // R1
   AST_UNLOCK_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr != A_KEY) |=> !unlocked); // R2
endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter #(
   parameter int CNT_W    = 31,
   parameter int SCALE_W  = 4,
   parameter bit SATURATE = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic               clr,
   input  logic [SCALE_W-1:0] scale,
   output logic [CNT_W-1:0]   cnt,
   output logic [CNT_W-1:0]   scaled
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] cnt_nxt;

   generate
      if (SATURATE) begin : g_sat
         assign cnt_nxt = (cnt == CNT_MAX) ? cnt : cnt + 1'b1;
      end else begin : g_wrap
         assign cnt_nxt = cnt + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else if (run) cnt <= cnt_nxt;
   end

   assign scaled = cnt >> scale;

   AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !clr) |=> $stable(cnt)); // R4
   AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0)); // R3

   generate
      if (SATURATE) begin : g_sat_chk
         AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt == CNT_MAX && !clr) |=> (cnt == CNT_MAX)); // R9
      end
   endgenerate
endmodule

// File: rtl/kwdt_match.sv
module kwdt_match #(
   parameter int CNT_W = 31,
   parameter int CMP_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] scaled,
   input  logic [CMP_W-1:0] cmp,
   input  logic             rst_en,
   input  logic             pend_wr,
   input  logic             pend_wval,
   output logic             match,
   output logic             pend,
   output logic             rst_pulse
);
   localparam int W = (CNT_W > CMP_W) ? CNT_W : CMP_W;

   logic [W-1:0] lhs;
   logic [W-1:0] rhs;

   assign lhs   = W'(scaled);
   assign rhs   = W'(cmp);
   assign match = (lhs >= rhs);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend      <= 1'b0;
         rst_pulse <= 1'b0;
      end else begin
         if (pend_wr)    pend <= pend_wval;
         else if (match) pend <= 1'b1;
         rst_pulse <= rst_en && match && !pend && !pend_wr;
      end
   end

   AST_PEND_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (match && !pend_wr) |=> pend); // R6
   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rst_pulse |=> !rst_pulse); // R7
   AST_PULSE_WITH_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      rst_pulse |-> (pend && $rose(pend))); // R7
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
   import kwdt_pkg::*;
#(
   parameter int ADDR_W   = 6,
   parameter int CNT_W    = 31,
   parameter int CMP_W    = 16,
   parameter int SCALE_W  = 4,
   parameter bit SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              core_awake,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_pending,
   output logic              wdt_reset
);
   generate
      if (CNT_W < 2 || CNT_W > DATA_W - 1) begin : g_bad_cnt
         initial $fatal(1, "kwdt_top: CNT_W out of range");
      end
      if (CMP_W < 1 || CMP_W > DATA_W) begin : g_bad_cmp
         initial $fatal(1, "kwdt_top: CMP_W out of range");
      end
      if (SCALE_W < 1 || SCALE_W > B_RST_EN) begin : g_bad_scale
         initial $fatal(1, "kwdt_top: SCALE_W collides with mode bits");
      end
      if ((1 << ADDR_W) <= OFF_CMP) begin : g_bad_addr
         initial $fatal(1, "kwdt_top: ADDR_W too narrow for register map");
      end
   endgenerate

   mode_t              mode;
   logic [SCALE_W-1:0] scale;
   logic [CMP_W-1:0]   cmp;
   logic               pend_wr, pend_wval, feed_clr;
   logic [CNT_W-1:0]   cnt, scaled;
   logic               match, pend, run, clr;

   kwdt_regs #(.ADDR_W(ADDR_W), .CMP_W(CMP_W), .SCALE_W(SCALE_W)) regs_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .mode(mode), .scale(scale), .cmp(cmp),
      .pend_wr(pend_wr), .pend_wval(pend_wval), .feed_clr(feed_clr)
   );

   assign run = mode.run_always || (mode.run_awake && core_awake);
   assign clr = feed_clr || (mode.auto_clr && match);

   kwdt_counter #(.CNT_W(CNT_W), .SCALE_W(SCALE_W), .SATURATE(SATURATE)) cnt_i (
      .clk(clk), .rst_n(rst_n), .run(run), .clr(clr), .scale(scale),
      .cnt(cnt), .scaled(scaled)
   );

   kwdt_match #(.CNT_W(CNT_W), .CMP_W(CMP_W)) match_i (
      .clk(clk), .rst_n(rst_n), .scaled(scaled), .cmp(cmp),
      .rst_en(mode.rst_en), .pend_wr(pend_wr), .pend_wval(pend_wval),
      .match(match), .pend(pend), .rst_pulse(wdt_reset)
   );

   assign irq_pending = pend;

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADDR_W'(OFF_CFG): begin
            bus_rdata[SCALE_W-1:0]  = scale;
            bus_rdata[B_RST_EN]     = mode.rst_en;
            bus_rdata[B_AUTO_CLR]   = mode.auto_clr;
            bus_rdata[B_RUN_ALWAYS] = mode.run_always;
            bus_rdata[B_RUN_AWAKE]  = mode.run_awake;
            bus_rdata[B_PEND]       = pend;
         end
         ADDR_W'(OFF_RAW):    bus_rdata = DATA_W'(cnt);
         ADDR_W'(OFF_SCALED): bus_rdata = DATA_W'(scaled);
         ADDR_W'(OFF_CMP):    bus_rdata = DATA_W'(cmp);
         default:             bus_rdata = '0;
      endcase
   end

   AST_AUTOCLR_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (mode.auto_clr && match) |=> (cnt == '0)); // R8
endmodule

// File: tb/kwdt_top_tb_top.sv
module kwdt_top_tb_top;
   localparam int CW   = 10;
   localparam int CMAX = (1 << CW) - 1;
   localparam logic [31:0] KEY  = 32'h0051_F15E;
   localparam logic [31:0] FOOD = 32'h0D09_F00D;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        core_awake = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_pending, wdt_reset;

   int checks = 0;
   int errors = 0;
   int pulses = 0;
   int cycles = 0;
   logic done = 1'b0;

   always #2.5 clk = ~clk;

   kwdt_top #(.CNT_W(CW)) dut_i (
      .clk(clk), .rst_n(rst_n), .core_awake(core_awake), .bus_addr(bus_addr),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_pending(irq_pending), .wdt_reset(wdt_reset)
   );

   always @(negedge clk) if (wdt_reset) pulses++;

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         errors++; checks++;
         $display("FAIL watchdog expired got %0d cycles expected < 150000", cycles);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got 0x%08h expected 0x%08h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic kwr(input logic [5:0] a, input logic [31:0] d);
      wr(6'h1C, KEY);
      wr(a, d);
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   logic [31:0] r, a0, a1, v;
   int p0;

   initial begin
      idle(3);
      rst_n = 1'b1;
      // R10 reset values, read without key
      rd(6'h00, r); chk("R10 cfg reset", r, 32'h0);
      rd(6'h08, r); chk("R10 count reset", r, 32'h0);
      rd(6'h20, r); chk("R10 cmp reset", r, 32'h0000_FFFF);
      chk("R10 irq reset", {31'b0, irq_pending}, 32'h0);
      // R1 locked write ignored
      wr(6'h20, 32'h1234);
      rd(6'h20, r); chk("R1 locked cmp write", r, 32'h0000_FFFF);
      wr(6'h1C, 32'h0051_F15F);
      wr(6'h20, 32'h1234);
      rd(6'h20, r); chk("R1 wrong key", r, 32'h0000_FFFF);
      kwr(6'h20, 32'h0100);
      rd(6'h20, r); chk("R1 keyed cmp write", r, 32'h0000_0100);
      // R2 unlock spent by ignored write
      kwr(6'h08, 32'h55);
      wr(6'h20, 32'h0200);
      rd(6'h20, r); chk("R2 unlock spent", r, 32'h0000_0100);
      // R4 run always
      kwr(6'h00, 32'h1000);
      rd(6'h08, a0); idle(19); rd(6'h08, a1);
      chk("R4 always rate", a1 - a0, 32'd20);
      // R4 awake gated
      kwr(6'h00, 32'h2000);
      rd(6'h08, a0); idle(19); rd(6'h08, a1);
      chk("R4 awake low holds", a1 - a0, 32'd0);
      core_awake = 1'b1;
      rd(6'h08, a0); idle(19); rd(6'h08, a1);
      chk("R4 awake high runs", a1 - a0, 32'd20);
      core_awake = 1'b0;
      // R4 hold
      kwr(6'h00, 32'h0);
      rd(6'h08, a0); idle(19); rd(6'h08, a1);
      chk("R4 hold", a1 - a0, 32'd0);
      v = a1;
      // R5 scale sweep on held count
      for (int s = 0; s < 16; s++) begin
         kwr(6'h00, 32'(s));
         rd(6'h10, r); chk($sformatf("R5 scale %0d", s), r, v >> s);
      end
      // R6 pending threshold sweep, R7 no pulse without enable
      p0 = pulses;
      for (int s = 0; s < 4; s++) begin
         kwr(6'h00, 32'(s));
         kwr(6'h20, (v >> s) + 1);
         idle(2);
         chk($sformatf("R6 below s%0d", s), {31'b0, irq_pending}, 32'h0);
         kwr(6'h20, v >> s);
         idle(2);
         rd(6'h00, r);
         chk($sformatf("R6 at s%0d", s), {31'b0, r[28]}, 32'h1);
         kwr(6'h20, (v >> s) + 1);
         kwr(6'h00, 32'(s));
         idle(2);
         chk($sformatf("R6 cleared s%0d", s), {31'b0, irq_pending}, 32'h0);
      end
      chk("R7 no pulse when disabled", 32'(pulses - p0), 32'd0);
      // R7 pulse with enable
      kwr(6'h00, 32'h100);
      p0 = pulses;
      kwr(6'h20, v);
      idle(10);
      chk("R7 one pulse", 32'(pulses - p0), 32'd1);
      chk("R7 pending set", {31'b0, irq_pending}, 32'h1);
      // R3 feed
      kwr(6'h20, 32'hFFFF);
      kwr(6'h00, 32'h0);
      kwr(6'h18, 32'h1234_5678);
      rd(6'h08, r); chk("R3 wrong feed", r, v);
      kwr(6'h18, FOOD);
      rd(6'h08, r); chk("R3 feed clears", r, 32'h0);
      // R8 auto clear
      kwr(6'h20, 32'd5);
      kwr(6'h00, 32'h1200);
      a1 = 0;
      for (int i = 0; i < 30; i++) begin
         rd(6'h08, r);
         if (r > a1) a1 = r;
      end
      chk("R8 count bounded", 32'(a1 <= 5), 32'h1);
      chk("R8 pending", {31'b0, irq_pending}, 32'h1);
      // R9 saturation
      kwr(6'h20, 32'hFFFF);
      kwr(6'h00, 32'h1000);
      kwr(6'h18, FOOD);
      idle(CMAX + 40);
      rd(6'h08, r); chk("R9 saturated", r, CMAX);
      idle(10);
      rd(6'h08, r); chk("R9 stays saturated", r, CMAX);
      kwr(6'h00, 32'h0);
      for (int s = 0; s < 16; s++) begin
         kwr(6'h00, 32'(s));
         rd(6'h10, r); chk($sformatf("R5 sat scale %0d", s), r, CMAX >> s);
      end
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule